// File: doc/BRIEF.md
# Snooping Invalidation Coherence Cluster

This block keeps one coherent view of a small set of memory lines among several processors that share a single bus. Each processor has its own line-state controller. The controller answers local reads and writes from its own copy whenever the state allows it. When it cannot, it asks for the bus. A fixed-priority arbiter grants one transaction per cycle. The cycle that holds the grant is also the cycle in which the transaction completes. Every other controller and a memory-side model watch that transaction.

A write to a line the processor does not own sends an invalidate across the bus. Every other holder then drops its copy, and memory stops trusting its own copy of the line. The writer becomes the sole owner and can write again without using the bus. A later bus read of an owned line is answered by the owner, not by memory. Memory picks up that data from the bus in the same cycle and serves the line again from then on. The owner keeps a shared copy.

Each line has three states: Invalid (code 0), Shared (code 1) and Owned (code 2). Each line holds one data word of DW bits, so a write replaces the whole line.

Top module: `snoop_inval_cluster`

## Requirements
- R1: Reset does the following. Every line of every controller is Invalid, no bus command is driven, no response is pending and no controller is busy. Memory is valid for every line, and line a holds the value (a*37+5) mod 2^DW.
- R2: A read of a line that is Invalid puts one read transaction on the bus (bus_cmd_o = 1). When the bus is free, the read completes 3 cycles after the request pulse and returns the bus data. The line becomes Shared.
- R3: A write to a line that is Invalid or Shared puts exactly one invalidate transaction on the bus (bus_cmd_o = 2). When the bus is free, the write completes 3 cycles after the request pulse, and the line becomes Owned with the written word.
- R4: A controller that observes another controller's invalidate for a line it holds moves that line to Invalid. Its next read of the line is therefore a miss that uses the bus.
- R5: The following complete 2 cycles after the request pulse with no bus transaction: a read of a Shared or Owned line, and a write to an Owned line.
- R6: After an invalidate, memory does not answer reads of that line. A read of such a line returns the last written word, never the stale memory word.
- R7: When another controller reads a line that this controller holds as Owned, this controller drives its current word onto the bus and raises bus_sup_o. It then keeps the line as Shared, so its next read needs no bus and its next write needs an invalidate.
- R8: When an owner supplies data, memory stores the supplied word and becomes valid for the line again. A later read of the line from a third controller is answered by memory, with bus_sup_o low and the correct word.
- R9: At most one bus transaction happens per cycle. Among controllers that request the bus in the same cycle, the lowest index is granted first. A controller that loses waits one cycle for each transaction ahead of it.
- R10: A bus transaction from another controller can touch the line of a local request that is being evaluated in that same cycle. When it does, the bus transaction takes effect first, and the local request is evaluated again in the next cycle against the updated state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NCPU | One-cycle request pulse per processor, taken only when that processor is not busy |
| req_write | input | NCPU | 1 = write, 0 = read, per processor |
| req_addr | input | NCPU*AW | Line index per processor |
| req_wdata | input | NCPU*DW | Write word per processor |
| busy | output | NCPU | Request in progress per processor |
| rsp_done | output | NCPU | One-cycle completion pulse per processor |
| rsp_rdata | output | NCPU*DW | Read word (or the word written), valid when rsp_done is high |
| bus_gnt_o | output | NCPU | Current bus grant, one-hot or zero |
| bus_cmd_o | output | 2 | Bus command: 0 idle, 1 read, 2 invalidate |
| bus_addr_o | output | AW | Line index of the current bus transaction |
| bus_data_o | output | DW | Data on the bus during a read |
| bus_sup_o | output | 1 | High when a cache, not memory, supplies the read data |

## Verification
The hardest case to reach from the ports is R10. It needs an invalidate from one processor to land on the same line in the very cycle that another processor's hit lookup for that line is evaluated. The bench sets this up as follows. Two processors first read the same line so that both hold it Shared. Then one processor writes the line, and the other processor issues a read exactly one cycle later. The write's invalidate then meets the pending read lookup. The read must miss, take 4 cycles and return the new word from the owner. The arbitration order is reached by issuing two writes to one line in the same cycle.

// File: rtl/snoop_coh_pkg.sv
package snoop_coh_pkg;

  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHD = 2'd1,
    LN_OWN = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_RD   = 2'd1,
    BUS_INV  = 2'd2
  } bus_cmd_e;

  // Reset content of memory for a line index
  function automatic logic [31:0] mem_seed(input int unsigned a);
    return (32'(a) * 32'd37) + 32'd5;
  endfunction

endpackage

// File: rtl/snoop_fixed_arb.sv
module snoop_fixed_arb #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    logic taken;
    taken = 1'b0;
    gnt   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !taken) begin
        gnt[i] = 1'b1;
        taken  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/snoop_mem_model.sv
module snoop_mem_model import snoop_coh_pkg::*; #(
  parameter  int NLINE = 4,
  parameter  int DW    = 8,
  localparam int AW    = $clog2(NLINE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_cmd,
  input  logic [AW-1:0]    bus_addr,
  input  logic             sup_any,
  input  logic [DW-1:0]    sup_data,
  output logic             mem_drive,
  output logic [DW-1:0]    mem_rdata,
  output logic [NLINE-1:0] mem_ok
);
  logic [DW-1:0] md [NLINE];

  assign mem_drive = (bus_cmd == BUS_RD) && mem_ok[bus_addr];
  assign mem_rdata = md[bus_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINE; i++) begin
        md[i] <= DW'(mem_seed(i));
      end
      mem_ok <= '1;
    end else begin
      if (bus_cmd == BUS_INV) begin
        mem_ok[bus_addr] <= 1'b0;
      end else if (bus_cmd == BUS_RD && sup_any) begin
        md[bus_addr]     <= sup_data;
        mem_ok[bus_addr] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/snoop_line_ctrl.sv
module snoop_line_ctrl import snoop_coh_pkg::*; #(
  parameter  int NLINE = 4,
  parameter  int DW    = 8,
  localparam int AW    = $clog2(NLINE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             busy,
  output logic             rsp_done,
  output logic [DW-1:0]    rsp_rdata,
  output logic             bus_req,
  input  logic             bus_gnt,
  output logic [1:0]       want_cmd,
  output logic [AW-1:0]    want_addr,
  input  logic [1:0]       snp_cmd,
  input  logic [AW-1:0]    snp_addr,
  input  logic [DW-1:0]    snp_data,
  output logic             sup_valid,
  output logic [DW-1:0]    sup_data,
  output logic [NLINE-1:0] own_map
);
  typedef enum logic [1:0] {C_IDLE, C_PEND, C_WAIT} ctrl_e;

  line_st_e      st [NLINE];
  logic [DW-1:0] ld [NLINE];
  ctrl_e         fsm;
  logic          p_write;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_wdata;

  // Named internal events
  logic snooping, ev_clash, local_hit, need_bus, xact_done;

  assign snooping  = (snp_cmd != BUS_IDLE) && !bus_gnt;
  assign sup_valid = snooping && (snp_cmd == BUS_RD) && (st[snp_addr] == LN_OWN);
  assign sup_data  = ld[snp_addr];
  assign ev_clash  = (fsm == C_PEND) && snooping && (snp_addr == p_addr);
  assign local_hit = (fsm == C_PEND) && !ev_clash &&
                     (p_write ? (st[p_addr] == LN_OWN) : (st[p_addr] != LN_INV));
  assign need_bus  = (fsm == C_PEND) && !ev_clash && !local_hit;
  assign xact_done = (fsm == C_WAIT) && bus_gnt;

  assign busy      = (fsm != C_IDLE);
  assign bus_req   = (fsm == C_WAIT);
  assign want_cmd  = p_write ? BUS_INV : BUS_RD;
  assign want_addr = p_addr;

  for (genvar i = 0; i < NLINE; i++) begin : g_own
    assign own_map[i] = (st[i] == LN_OWN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm       <= C_IDLE;
      p_write   <= 1'b0;
      p_addr    <= '0;
      p_wdata   <= '0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
      for (int i = 0; i < NLINE; i++) begin
        st[i] <= LN_INV;
        ld[i] <= '0;
      end
    end else begin
      rsp_done <= 1'b0;
      // Remote transactions observed on the bus
      if (snooping) begin
        if (snp_cmd == BUS_INV) begin
          st[snp_addr] <= LN_INV;
        end else if (snp_cmd == BUS_RD && st[snp_addr] == LN_OWN) begin
          st[snp_addr] <= LN_SHD;
        end
      end
      case (fsm)
        C_IDLE: begin
          if (req_valid) begin
            p_write <= req_write;
            p_addr  <= req_addr;
            p_wdata <= req_wdata;
            fsm     <= C_PEND;
          end
        end
        C_PEND: begin
          if (local_hit) begin
            if (p_write) ld[p_addr] <= p_wdata;
            rsp_rdata <= p_write ? p_wdata : ld[p_addr];
            rsp_done  <= 1'b1;
            fsm       <= C_IDLE;
          end else if (need_bus) begin
            fsm <= C_WAIT;
          end
        end
        C_WAIT: begin
          if (xact_done) begin
            st[p_addr] <= p_write ? LN_OWN : LN_SHD;
            ld[p_addr] <= p_write ? p_wdata : snp_data;
            rsp_rdata  <= p_write ? p_wdata : snp_data;
            rsp_done   <= 1'b1;
            fsm        <= C_IDLE;
          end
        end
        default: fsm <= C_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/snoop_inval_cluster.sv
module snoop_inval_cluster import snoop_coh_pkg::*; #(
  parameter  int NCPU  = 3,
  parameter  int NLINE = 4,
  parameter  int DW    = 8,
  localparam int AW    = $clog2(NLINE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCPU-1:0]   req_valid,
  input  logic [NCPU-1:0]   req_write,
  input  logic [NCPU*AW-1:0] req_addr,
  input  logic [NCPU*DW-1:0] req_wdata,
  output logic [NCPU-1:0]   busy,
  output logic [NCPU-1:0]   rsp_done,
  output logic [NCPU*DW-1:0] rsp_rdata,
  output logic [NCPU-1:0]   bus_gnt_o,
  output logic [1:0]        bus_cmd_o,
  output logic [AW-1:0]     bus_addr_o,
  output logic [DW-1:0]     bus_data_o,
  output logic              bus_sup_o
);
  logic [NCPU-1:0]       bus_req, bus_gnt, sup_vec;
  logic [1:0]            want_cmd  [NCPU];
  logic [AW-1:0]         want_addr [NCPU];
  logic [DW-1:0]         sup_dat   [NCPU];
  logic [NCPU*NLINE-1:0] own_map;
  logic [1:0]            bus_cmd;
  logic [AW-1:0]         bus_addr;
  logic [DW-1:0]         bus_data, sup_mux, mem_rdata;
  logic                  sup_any, mem_drive;
  logic [NLINE-1:0]      mem_ok;

  snoop_fixed_arb #(.N(NCPU)) u_arb (.req(bus_req), .gnt(bus_gnt));

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    snoop_line_ctrl #(.NLINE(NLINE), .DW(DW)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid[c]),
      .req_write (req_write[c]),
      .req_addr  (req_addr[c*AW +: AW]),
      .req_wdata (req_wdata[c*DW +: DW]),
      .busy      (busy[c]),
      .rsp_done  (rsp_done[c]),
      .rsp_rdata (rsp_rdata[c*DW +: DW]),
      .bus_req   (bus_req[c]),
      .bus_gnt   (bus_gnt[c]),
      .want_cmd  (want_cmd[c]),
      .want_addr (want_addr[c]),
      .snp_cmd   (bus_cmd),
      .snp_addr  (bus_addr),
      .snp_data  (bus_data),
      .sup_valid (sup_vec[c]),
      .sup_data  (sup_dat[c]),
      .own_map   (own_map[c*NLINE +: NLINE])
    );
  end

  // Bus multiplexing from the granted requester and the supplier
  always_comb begin
    bus_cmd  = '0;
    bus_addr = '0;
    sup_mux  = '0;
    for (int c = 0; c < NCPU; c++) begin
      if (bus_gnt[c]) begin
        bus_cmd  = bus_cmd | want_cmd[c];
        bus_addr = bus_addr | want_addr[c];
      end
      if (sup_vec[c]) sup_mux = sup_mux | sup_dat[c];
    end
  end

  assign sup_any  = |sup_vec;
  assign bus_data = sup_any ? sup_mux : (mem_drive ? mem_rdata : '0);

  snoop_mem_model #(.NLINE(NLINE), .DW(DW)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_cmd   (bus_cmd),
    .bus_addr  (bus_addr),
    .sup_any   (sup_any),
    .sup_data  (sup_mux),
    .mem_drive (mem_drive),
    .mem_rdata (mem_rdata),
    .mem_ok    (mem_ok)
  );

  assign bus_gnt_o  = bus_gnt;
  assign bus_cmd_o  = bus_cmd;
  assign bus_addr_o = bus_addr;
  assign bus_data_o = bus_data;
  assign bus_sup_o  = sup_any;
endmodule

// File: rtl/snoop_inval_chk.sv
module snoop_inval_chk #(
  parameter  int NCPU  = 3,
  parameter  int NLINE = 4,
  localparam int AW    = $clog2(NLINE)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            bus_cmd,
  input logic [AW-1:0]         bus_addr,
  input logic [NCPU-1:0]       bus_gnt,
  input logic [NCPU-1:0]       sup_vec,
  input logic [NLINE-1:0]      mem_ok,
  input logic [NCPU*NLINE-1:0] own_map
);
  // R9
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_gnt));

  // R7
  single_supplier_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sup_vec));

  // R6
  inv_closes_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == 2'd2) |=> !mem_ok[$past(bus_addr)]);

  // R6
  supplier_not_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|sup_vec) |-> !mem_ok[bus_addr]);

  // R8
  rd_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == 2'd1) |-> (mem_ok[bus_addr] || (|sup_vec)));

  // R8
  sup_refills_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|sup_vec) |=> mem_ok[$past(bus_addr)]);

  for (genvar l = 0; l < NLINE; l++) begin : g_line
    logic [NCPU-1:0] owners;
    for (genvar c = 0; c < NCPU; c++) begin : g_col
      assign owners[c] = own_map[c*NLINE + l];
    end
    // R3
    single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(owners) <= 1);
    // R6
    owner_mem_stale_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|owners) |-> !mem_ok[l]);
  end
endmodule

bind snoop_inval_cluster snoop_inval_chk #(.NCPU(NCPU), .NLINE(NLINE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_cmd  (bus_cmd),
  .bus_addr (bus_addr),
  .bus_gnt  (bus_gnt),
  .sup_vec  (sup_vec),
  .mem_ok   (mem_ok),
  .own_map  (own_map)
);

// File: tb/tb_snoop_inval_cluster.sv
module tb_snoop_inval_cluster;
  localparam int N  = 3;
  localparam int NL = 4;
  localparam int DW = 8;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0, req_write = '0;
  logic [N*AW-1:0] req_addr = '0;
  logic [N*DW-1:0] req_wdata = '0;
  logic [N-1:0]    busy, rsp_done, bus_gnt_o;
  logic [N*DW-1:0] rsp_rdata;
  logic [1:0]      bus_cmd_o;
  logic [AW-1:0]   bus_addr_o;
  logic [DW-1:0]   bus_data_o;
  logic            bus_sup_o;

  always #10 clk = ~clk;

  snoop_inval_cluster #(.NCPU(N), .NLINE(NL), .DW(DW)) dut (.*);

  typedef struct { int cpu; bit rd; int d; } exp_t;
  exp_t sbq[$];
  int checks = 0, errors = 0;
  int n_rd = 0, n_inv = 0, n_sup = 0;
  bit finished = 1'b0;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: bus counters and scoreboard pops
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_cmd_o == 2'd1) n_rd++;
      if (bus_cmd_o == 2'd2) n_inv++;
      if (bus_sup_o) n_sup++;
      for (int c = 0; c < N; c++) begin
        if (rsp_done[c]) begin
          int idx;
          idx = -1;
          for (int k = 0; k < sbq.size(); k++) begin
            if (sbq[k].cpu == c) begin idx = k; break; end
          end
          if (idx < 0) begin
            check(1'b0, "R2 unexpected response", c, -1);
          end else begin
            if (sbq[idx].rd)
              check(int'(rsp_rdata[c*DW +: DW]) == sbq[idx].d, "R2/R6/R7/R8 read data",
                    int'(rsp_rdata[c*DW +: DW]), sbq[idx].d);
            sbq.delete(idx);
          end
        end
      end
    end
  end

  // Driver: pushes expectation, pulses request, measures latency
  task automatic run(int c, bit wr, int a, int d, int delay, output int lat);
    exp_t e;
    repeat (delay) @(negedge clk);
    e.cpu = c; e.rd = !wr; e.d = d;
    sbq.push_back(e);
    req_valid[c] = 1'b1;
    req_write[c] = wr;
    req_addr[c*AW +: AW] = AW'(a);
    req_wdata[c*DW +: DW] = DW'(d);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) req_valid[c] = 1'b0;
    end while (!rsp_done[c] && lat < 30);
  endtask

  task automatic op(int c, bit wr, int a, int d, int e_lat, int e_rd, int e_inv,
                    int e_sup, string tag);
    int r0, i0, s0, lat;
    r0 = n_rd; i0 = n_inv; s0 = n_sup;
    run(c, wr, a, d, 0, lat);
    #1;
    check(lat == e_lat, {tag, " latency"}, lat, e_lat);
    check(n_rd - r0 == e_rd, {tag, " bus reads"}, n_rd - r0, e_rd);
    check(n_inv - i0 == e_inv, {tag, " bus invalidates"}, n_inv - i0, e_inv);
    check(n_sup - s0 == e_sup, {tag, " cache supplies"}, n_sup - s0, e_sup);
  endtask

  function automatic int seed(int a);
    return (a * 37 + 5) % 256;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int l1, l2, i0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    check(busy == '0, "R1 busy after reset", int'(busy), 0);
    check(rsp_done == '0, "R1 no response after reset", int'(rsp_done), 0);
    check(bus_cmd_o == 2'd0, "R1 bus idle after reset", int'(bus_cmd_o), 0);

    op(0, 0, 1, seed(1), 3, 1, 0, 0, "R1 R2 first read miss");
    op(0, 0, 1, seed(1), 2, 0, 0, 0, "R5 shared read hit");
    op(1, 0, 1, seed(1), 3, 1, 0, 0, "R2 second reader");
    op(0, 1, 1, 'hC3, 3, 0, 1, 0, "R3 write to shared");
    op(0, 1, 1, 'h3C, 2, 0, 0, 0, "R5 owned write");
    op(1, 0, 1, 'h3C, 3, 1, 0, 1, "R4 R7 invalidated reader, owner supplies");
    op(0, 0, 1, 'h3C, 2, 0, 0, 0, "R7 owner keeps shared copy");
    op(2, 0, 1, 'h3C, 3, 1, 0, 0, "R8 memory answers after refill");
    op(0, 1, 1, 'h77, 3, 0, 1, 0, "R7 former owner write needs invalidate");
    op(2, 1, 2, 'h99, 3, 0, 1, 0, "R3 first write to invalid line");
    op(1, 0, 2, 'h99, 3, 1, 0, 1, "R6 memory stale after invalidate");

    // R9 simultaneous writes, lowest index first
    i0 = n_inv;
    fork
      run(1, 1, 3, 'h11, 0, l1);
      run(2, 1, 3, 'h22, 0, l2);
    join
    #1;
    check(l1 == 3, "R9 winner latency", l1, 3);
    check(l2 == 4, "R9 loser latency", l2, 4);
    check(n_inv - i0 == 2, "R9 two invalidates", n_inv - i0, 2);
    op(1, 0, 3, 'h22, 3, 1, 0, 1, "R9 R4 later writer owns the line");

    // R10 invalidate lands on a pending hit lookup
    op(0, 0, 0, seed(0), 3, 1, 0, 0, "R10 setup reader 0");
    op(1, 0, 0, seed(0), 3, 1, 0, 0, "R10 setup reader 1");
    fork
      run(0, 1, 0, 'h5A, 0, l1);
      run(1, 0, 0, 'h5A, 1, l2);
    join
    #1;
    check(l1 == 3, "R10 writer latency", l1, 3);
    check(l2 == 4, "R10 colliding reader re-evaluated", l2, 4);
    check(sbq.size() == 0, "R2 scoreboard drained", sbq.size(), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule